// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Generator

This block produces one pulse-width-modulated output from a single 32-bit control word. The word carries a run bit, the pin level to hold while stopped, an 8-bit divisor field and an 8-bit duty field. When running, the system clock is first divided by a fixed base factor (2^BASE_LOG2, 256 by default) times the divisor. The result paces an 8-bit phase counter, so one output period always spans 256 phase steps.

The duty field states how many of the 256 steps the output spends low at the start of each period. Larger values therefore shorten the high part of the waveform. Divisor and duty updates made while the generator runs are held back until the phase counter wraps, so no period is ever cut short. Stopping the generator puts the programmed idle level on the pin in the cycle after the write. It also returns both counters to zero, so the next start begins a fresh period.

The control word is written through a byte-strobed write port and is always visible on a read-data output.

Top module: `prescaled_pwm`

## Requirements
- R1: After reset the control word reads 0x0000_0000 and `pwm_out` is 0.
- R2: While bit 31 (run) is 0, `pwm_out` equals bit 30 (idle level) from the cycle after the write, and the level does not change while the word is left alone.
- R3: A write changes only the bytes whose `wr_strb` bit is set (strobe bit k covers data bits 8k+7:8k). Bits 29:16 always read 0. Bits 31, 30 and 15:0 read back as last written.
- R4: While running, the phase counter advances once every 2^BASE_LOG2 × N system cycles. N is bits 15:8, with the value 0 meaning 256.
- R5: While running, `pwm_out` is 0 while the phase count is below D (bits 7:0) and 1 otherwise, over a period of 256 phase steps. With D = 0 the output stays 1, and with D = 255 it is 1 for only the last step.
- R6: A divisor or duty value written while running leaves the current period unchanged and governs every period after the next phase wrap.
- R7: Setting bit 31 starts the period at phase 0 with an empty prescaler, using the divisor and duty values written with or before the enabling write.
- R8: Clearing bit 31 while running shows the idle level on the next cycle. A later re-enable restarts from phase 0, giving a full D-step low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write the control word on this edge |
| wr_strb | input | 4 | Byte strobes for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| pwm_out | output | 1 | PWM output pin |

## Verification
A write is taken at a rising edge, and both `rd_data` and `pwm_out` show its effect right after that edge. The bench therefore drives inputs on falling edges and samples on the next falling edge. Each phase step lasts 2·N system cycles in the bench (BASE_LOG2 = 1). Low and high run lengths are counted in falling-edge samples starting with the one straight after a write, so a low run after enabling must equal exactly D·2·N samples. A cycle-by-cycle model updated on rising edges also compares the pin and the read-back word at every falling edge during a random phase.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned RUN_BIT  = 31;
   localparam int unsigned IDLE_BIT = 30;
   localparam int unsigned DIV_LSB  = 8;
   localparam int unsigned DUTY_LSB = 0;
   localparam int unsigned NBYTES   = REG_W / 8;
   // writable bits of the control word; the rest read as zero
   localparam logic [REG_W-1:0] KEEP_MASK = 32'hC000_FFFF;
endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
   import pwm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NBYTES-1:0] wr_strb,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  cfg_q,
   output logic [REG_W-1:0]  cfg_d
);

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign cfg_d[8*b +: 8] = (wr_en && wr_strb[b])
                             ? (wr_data[8*b +: 8] & KEEP_MASK[8*b +: 8])
                             : cfg_q[8*b +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_d;
   end

   // R3: bytes without a strobe hold their value
   a_r3_top_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_strb[3]) |=> $stable(cfg_q[31:24]));
   a_r3_low_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_strb[0]) |=> $stable(cfg_q[7:0]));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int unsigned BASE_LOG2 = 8,
   parameter int unsigned DIV_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int unsigned CNT_W = BASE_LOG2 + DIV_W + 1;

   logic [DIV_W:0]   n_eff;
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] last;
   logic [CNT_W-1:0] cnt;

   // a zero divisor selects the largest division
   assign n_eff = (div == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, div};

   if (BASE_LOG2 == 0) begin : g_no_base
      assign limit = n_eff;
   end else begin : g_base
      assign limit = {n_eff, {BASE_LOG2{1'b0}}};
   end

   assign last = limit - CNT_W'(1);
   assign tick = run && (cnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (tick)      cnt <= '0;
      else                cnt <= cnt + CNT_W'(1);
   end

   // R4: the count never passes the terminal value of the active divisor
   a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt <= last);
   // R8: a stopped prescaler is empty
   a_r8_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
   parameter int unsigned PHASE_W = 8,
   parameter int unsigned DIV_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic [DIV_W-1:0]   div_nxt,
   input  logic [PHASE_W-1:0] duty_nxt,
   output logic [DIV_W-1:0]   div_act,
   output logic [PHASE_W-1:0] duty_act,
   output logic [PHASE_W-1:0] phase
);
   logic wrap;
   logic load;

   assign wrap = tick && (phase == {PHASE_W{1'b1}});
   // while stopped the active fields follow the register; while running only at wrap
   assign load = !run || wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_act  <= '0;
         duty_act <= '0;
      end else if (load) begin
         div_act  <= div_nxt;
         duty_act <= duty_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) phase <= '0;
      else if (tick)      phase <= phase + PHASE_W'(1);
   end

   // R6: active fields only move at a period boundary while running
   a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> ($stable(duty_act) && $stable(div_act)));
   // R4: phase steps only on a prescaler tick
   a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(phase));
   // R7: a fresh start begins at phase zero
   a_r7_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> phase == '0);

endmodule

// File: rtl/prescaled_pwm.sv
module prescaled_pwm
   import pwm_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 8,
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned PHASE_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NBYTES-1:0] wr_strb,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic              pwm_out
);
   initial begin
      a_div_w_fits: assert (DIV_W >= 1 && DIV_W <= 8)
         else $error("DIV_W must fit its 8-bit field");
      a_phase_w_fits: assert (PHASE_W >= 1 && PHASE_W <= 8)
         else $error("PHASE_W must fit its 8-bit field");
      a_base_sane: assert (BASE_LOG2 <= 16)
         else $error("BASE_LOG2 too large");
   end

   logic [REG_W-1:0]   cfg_q;
   logic [REG_W-1:0]   cfg_d;
   logic               run;
   logic               tick;
   logic [DIV_W-1:0]   div_act;
   logic [PHASE_W-1:0] duty_act;
   logic [PHASE_W-1:0] phase;

   pwm_ctrl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_strb (wr_strb),
      .wr_data (wr_data),
      .cfg_q   (cfg_q),
      .cfg_d   (cfg_d)
   );

   assign run = cfg_q[RUN_BIT];

   pwm_prescaler #(.BASE_LOG2(BASE_LOG2), .DIV_W(DIV_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (div_act),
      .tick  (tick)
   );

   pwm_phase_gen #(.PHASE_W(PHASE_W), .DIV_W(DIV_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick),
      .div_nxt  (cfg_d[DIV_LSB +: DIV_W]),
      .duty_nxt (cfg_d[DUTY_LSB +: PHASE_W]),
      .div_act  (div_act),
      .duty_act (duty_act),
      .phase    (phase)
   );

   assign rd_data = cfg_q;
   // low while phase is below the duty count, high for the rest of the period
   assign pwm_out = run ? (phase >= duty_act) : cfg_q[IDLE_BIT];

   // R8: stopping shows the idle level at once
   a_r8_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[RUN_BIT]) |-> pwm_out == rd_data[IDLE_BIT]);
   // R5: every period opens low when the duty count is non-zero
   a_r5_open_low: assert property (@(posedge clk) disable iff (!rst_n)
      (run && phase == '0 && duty_act != '0) |-> !pwm_out);

endmodule

// File: tb/prescaled_pwm_tb.sv
`timescale 1ns/1ps
module prescaled_pwm_tb;
   localparam int BL2 = 1;
   localparam int BASE = 1 << BL2;
   localparam int WD_CYCLES = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_strb = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        pwm_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   prescaled_pwm #(.BASE_LOG2(BL2), .DIV_W(8), .PHASE_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_strb(wr_strb),
      .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int steps_len(input int div);
      return BASE * ((div == 0) ? 256 : div);
   endfunction

   // reference model, advanced on rising edges from the stable inputs
   logic [31:0] m_reg;
   logic [31:0] m_nreg;
   int m_cnt, m_phase, m_div, m_duty;
   bit model_on = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_reg = '0; m_cnt = 0; m_phase = 0; m_div = 0; m_duty = 0;
      end else begin
         m_nreg = m_reg;
         if (wr_en)
            for (int b = 0; b < 4; b++)
               if (wr_strb[b]) m_nreg[8*b +: 8] = wr_data[8*b +: 8];
         m_nreg = m_nreg & 32'hC000_FFFF;
         if (!m_reg[31]) begin
            m_cnt = 0; m_phase = 0;
            m_div = int'(m_nreg[15:8]); m_duty = int'(m_nreg[7:0]);
         end else if (m_cnt == steps_len(m_div) - 1) begin
            m_cnt = 0;
            if (m_phase == 255) begin
               m_phase = 0;
               m_div = int'(m_nreg[15:8]); m_duty = int'(m_nreg[7:0]);
            end else m_phase++;
         end else m_cnt++;
         m_reg = m_nreg;
      end
   end

   always @(negedge clk) begin
      if (rst_n && model_on && !done) begin
         automatic bit exp_o = m_reg[31] ? (m_phase >= m_duty) : m_reg[30];
         chk(pwm_out == exp_o, "R5 model pin", int'(pwm_out), int'(exp_o));
         chk(rd_data == m_reg, "R3 model readback", int'(rd_data), int'(m_reg));
      end
   end

   // caller stands at a falling edge; returns at the next falling edge
   task automatic reg_wr(input logic [3:0] s, input logic [31:0] d);
      wr_en = 1'b1; wr_strb = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_strb = '0; wr_data = '0;
   endtask

   task automatic run_len(input bit lvl, input int lim, output int n);
      n = 0;
      while (pwm_out == lvl && n < lim) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      finish_up();
   end

   initial begin
      int n;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_data == 32'h0, "R1 reset word", int'(rd_data), 0);
      chk(pwm_out == 1'b0, "R1 reset pin", int'(pwm_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      model_on = 1;

      // R3 strobes and reserved bits
      reg_wr(4'hF, 32'hFFFF_FFFF);
      chk(rd_data == 32'hC000_FFFF, "R3 reserved read zero", int'(rd_data), int'(32'hC000_FFFF));
      // R2: run bit 31 = 1 here, so clear it with byte 3 only, idle bit 30 = 1
      reg_wr(4'b1000, 32'h4000_0000);
      chk(rd_data == 32'h4000_FFFF, "R3 low bytes kept", int'(rd_data), int'(32'h4000_FFFF));
      chk(pwm_out == 1'b1, "R2 idle high next cycle", int'(pwm_out), 1);
      reg_wr(4'b0011, 32'h0000_0000);
      chk(rd_data == 32'h4000_0000, "R3 top byte kept", int'(rd_data), int'(32'h4000_0000));
      repeat (100) @(negedge clk);
      chk(pwm_out == 1'b1, "R2 idle held", int'(pwm_out), 1);
      reg_wr(4'b1000, 32'h0000_0000);
      chk(pwm_out == 1'b0, "R2 idle low", int'(pwm_out), 0);

      // R7 + R4: N=3, D=10, enable in one write -> low 10*2*3 cycles
      reg_wr(4'hF, 32'h8000_030A);
      chk(pwm_out == 1'b0, "R7 starts low", int'(pwm_out), 0);
      run_len(1'b0, 5000, n);
      chk(n == 10 * steps_len(3), "R4 low run N=3", n, 10 * steps_len(3));
      run_len(1'b1, 5000, n);
      chk(n == 246 * steps_len(3), "R5 high run N=3", n, 246 * steps_len(3));

      // R8: stop mid-period with idle high, then restart
      repeat (7) @(negedge clk);
      reg_wr(4'b1000, 32'h4000_0000);
      chk(pwm_out == 1'b1, "R8 idle next cycle", int'(pwm_out), 1);
      reg_wr(4'b1000, 32'h8000_0000);
      run_len(1'b0, 5000, n);
      chk(n == 10 * steps_len(3), "R8 restart full low", n, 10 * steps_len(3));
      reg_wr(4'b1000, 32'h0000_0000);

      // R4: divisor 0 means 256
      reg_wr(4'hF, 32'h8000_0001);
      run_len(1'b0, 5000, n);
      chk(n == steps_len(0), "R4 zero divisor", n, BASE * 256);
      reg_wr(4'b1000, 32'h0000_0000);

      // R5: D=0 always high for a whole period (N=1)
      reg_wr(4'hF, 32'h8000_0100);
      run_len(1'b1, 600, n);
      chk(n == 600, "R5 duty zero all high", n, 600);
      reg_wr(4'b1000, 32'h0000_0000);

      // R5: D=255 high for one step
      reg_wr(4'hF, 32'h8000_01FF);
      run_len(1'b0, 5000, n);
      chk(n == 255 * BASE, "R5 duty 255 low", n, 255 * BASE);
      run_len(1'b1, 5000, n);
      chk(n == BASE, "R5 duty 255 high", n, BASE);
      reg_wr(4'b1000, 32'h0000_0000);

      // R6: duty change mid-period takes effect after wrap
      reg_wr(4'hF, 32'h8000_010A);
      run_len(1'b0, 5000, n);
      reg_wr(4'b0001, 32'h0000_00C8);
      run_len(1'b1, 5000, n);
      chk(n == 246 * BASE - 1, "R6 old period kept", n, 246 * BASE - 1);
      run_len(1'b0, 5000, n);
      chk(n == 200 * BASE, "R6 new duty low", n, 200 * BASE);
      run_len(1'b1, 5000, n);
      chk(n == 56 * BASE, "R6 new duty high", n, 56 * BASE);
      reg_wr(4'b1000, 32'h0000_0000);

      // random phase, checked by the model (R3 R4 R5 R6 R7 R8)
      for (int i = 0; i < 40; i++) begin
         automatic logic [31:0] d;
         d[31]    = ($urandom % 4) != 0;
         d[30]    = $urandom % 2;
         d[29:16] = 14'($urandom);
         d[15:8]  = 8'(1 + $urandom % 3);
         d[7:0]   = 8'($urandom);
         reg_wr(4'($urandom), d);
         repeat ($urandom % 1500) @(negedge clk);
      end

      finish_up();
   end
endmodule